// File: doc/BRIEF.md
# Virtual Access Translation and Protection Checker

This block sits between an address-generating pipeline stage and the memory interface. For each virtual access it decides, from the address region and the current privilege level, one of two things. Either the access bypasses translation and gets a fixed physical mapping, or it relies on a lookup result that an external translation buffer has already produced. It then applies the page protection and dirty-page rules. The result is either a physical address or a 12-bit exception code.

The translation storage itself is outside this block. The block only consumes the lookup outcome (miss, single hit or multiple hit), the page's protection field, its dirty bit and the translated address. Each accepted request yields a registered response one clock later. The outcome is decided by a fixed priority: region/privilege error first, then lookup failure, then protection, then the dirty check.

Top module: `vaddr_guard`

## Requirements
- R1: While and after reset, before any request, rsp_valid, rsp_fault, rsp_code and rsp_paddr are all zero.
- R2: In privileged mode (req_priv=1), an address in 0x80000000..0xBFFFFFFF is never translated and never faults. rsp_paddr is the address with bits 31:29 cleared, whatever the lookup inputs are.
- R3: In user mode (req_priv=0), an address in 0x80000000..0xBFFFFFFF, or an address at or above 0xE0000000 that lies outside the inclusive window 0xE0000000..0xE4000000, faults with code 0x100 for a write (req_kind=2) and 0x0C0 for any other kind.
- R4: An address at or above 0xE0000000 that does not fault under R3 passes through unchanged with no fault.
- R5: For addresses below 0x80000000 or in 0xC0000000..0xDFFFFFFF with xlate_on=0, rsp_paddr is the address with bits 31:29 cleared, with no fault.
- R6: With translation on, tlb_state=2 (multiple hit) faults with 0x140. tlb_state=0 or 3 (miss) faults with 0x060 for a write and 0x040 otherwise. tlb_state=1 is a hit.
- R7: On a hit for a data access (req_kind 1 = read, 2 = write, 3 = treated as read), it is a violation if req_priv=0 and tlb_prot is 0 or 1. It is also a violation if the access is a write and tlb_prot is 0 or 2. A violation faults with 0x0C0 for a write and 0x0A0 for a read.
- R8: On a hit for an instruction fetch (req_kind=0), req_priv=1 with tlb_prot bit 1 clear faults with 0x0A0. No other fetch hit faults.
- R9: A write hit that passes protection, where tlb_dirty=0, faults with 0x080.
- R10: A hit that raises no fault returns tlb_paddr on rsp_paddr.
- R11: Whenever rsp_fault is 1, rsp_paddr is zero and rsp_code is nonzero. When rsp_fault is 0, rsp_code is zero.
- R12: rsp_valid equals req_valid of the previous cycle. When req_valid is 0, rsp_paddr, rsp_fault and rsp_code keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_priv | input | 1 | 1 privileged, 0 user |
| xlate_on | input | 1 | Address translation enable |
| tlb_state | input | 2 | 0 miss, 1 hit, 2 multiple hit, 3 miss |
| tlb_prot | input | 2 | Protection field of the hit entry |
| tlb_dirty | input | 1 | Dirty bit of the hit entry |
| tlb_paddr | input | 32 | Translated physical address of the hit entry |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Access raises an exception |
| rsp_code | output | 12 | Exception code (zero when no fault) |

## Verification
The assertions assume that the lookup inputs describe the address currently presented. They also assume that all inputs are stable and known around each rising edge, and that reset is applied before the first request. The stimulus drives every input on falling edges only. It sweeps a set of addresses placed on each region boundary and on each edge of the store window, in both privilege levels, against every combination of access kind, lookup state, protection field and dirty bit. The lookup address is derived from the virtual one, so a hit result is always distinguishable from a bypass result.

// File: rtl/vg_pkg.sv
package vg_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_ALT   = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    LK_MISS  = 2'd0,
    LK_HIT   = 2'd1,
    LK_MULTI = 2'd2,
    LK_NONE  = 2'd3
  } lookup_e;

  localparam int CODE_W = 12;

  localparam logic [CODE_W-1:0] EC_NONE      = 12'h000;
  localparam logic [CODE_W-1:0] EC_MISS_RD   = 12'h040;
  localparam logic [CODE_W-1:0] EC_MISS_WR   = 12'h060;
  localparam logic [CODE_W-1:0] EC_FIRST_WR  = 12'h080;
  localparam logic [CODE_W-1:0] EC_PROT_RD   = 12'h0A0;
  localparam logic [CODE_W-1:0] EC_PROT_WR   = 12'h0C0;
  localparam logic [CODE_W-1:0] EC_ADDR_RD   = 12'h0C0;
  localparam logic [CODE_W-1:0] EC_ADDR_WR   = 12'h100;
  localparam logic [CODE_W-1:0] EC_MULTI     = 12'h140;

  typedef struct packed {
    logic              fault;
    logic [CODE_W-1:0] code;
  } verdict_t;

endpackage

// File: rtl/vg_region_dec.sv
module vg_region_dec #(
  parameter int ADDR_W = 32,
  parameter int KEEP_W = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              priv,
  output logic              untranslated,
  output logic              region_err,
  output logic [ADDR_W-1:0] direct_paddr,
  output logic [ADDR_W-1:0] fixed_paddr
);
  localparam logic [ADDR_W-1:0] KEEP_MASK = ADDR_W'((64'd1 << KEEP_W) - 64'd1);
  localparam logic [ADDR_W-1:0] SQ_LAST   = ADDR_W'(32'hE400_0000);

  logic in_p12;
  logic in_p4;
  logic in_sq;

  always_comb begin
    in_p12       = (vaddr[ADDR_W-1 -: 2] == 2'b10);
    in_p4        = (vaddr[ADDR_W-1 -: 3] == 3'b111);
    in_sq        = in_p4 && (vaddr <= SQ_LAST);
    region_err   = !priv && (in_p12 || (in_p4 && !in_sq));
    untranslated = in_p12 || in_p4;
    direct_paddr = vaddr & KEEP_MASK;
    fixed_paddr  = in_p12 ? (vaddr & KEEP_MASK) : vaddr;
  end

  // R3
  user_p12_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv && vaddr[ADDR_W-1 -: 2] == 2'b10) |-> region_err);

  // R4
  priv_no_region_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    priv |-> !region_err);

endmodule

// File: rtl/vg_prot_chk.sv
module vg_prot_chk
  import vg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  acc_kind_e kind,
  input  logic      priv,
  input  lookup_e   lk,
  input  logic [1:0] prot,
  input  logic      dirty,
  output verdict_t  verdict
);
  logic is_wr;
  logic is_fetch;
  logic fetch_bad;
  logic data_bad;

  always_comb begin
    is_wr     = (kind == ACC_WRITE);
    is_fetch  = (kind == ACC_FETCH);
    fetch_bad = priv && !prot[1];
    data_bad  = (!priv && !prot[1]) || (is_wr && !prot[0]);

    verdict = '{fault: 1'b0, code: EC_NONE};
    unique case (lk)
      LK_MULTI: verdict = '{fault: 1'b1, code: EC_MULTI};
      LK_HIT: begin
        if (is_fetch) begin
          if (fetch_bad) verdict = '{fault: 1'b1, code: EC_PROT_RD};
        end else if (data_bad) begin
          verdict = '{fault: 1'b1, code: is_wr ? EC_PROT_WR : EC_PROT_RD};
        end else if (is_wr && !dirty) begin
          verdict = '{fault: 1'b1, code: EC_FIRST_WR};
        end
      end
      default: verdict = '{fault: 1'b1, code: is_wr ? EC_MISS_WR : EC_MISS_RD};
    endcase
  end

  // R6
  multi_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk == LK_MULTI) |-> (verdict.fault && verdict.code == EC_MULTI));

  // R9
  first_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict.code == EC_FIRST_WR) |-> (kind == ACC_WRITE && !dirty && lk == LK_HIT));

  // R8
  fetch_user_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_FETCH && lk == LK_HIT && !priv) |-> !verdict.fault);

endmodule

// File: rtl/vaddr_guard.sv
module vaddr_guard
  import vg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int KEEP_W = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              req_priv,
  input  logic              xlate_on,
  input  logic [1:0]        tlb_state,
  input  logic [1:0]        tlb_prot,
  input  logic              tlb_dirty,
  input  logic [ADDR_W-1:0] tlb_paddr,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic [CODE_W-1:0] rsp_code
);
  logic              untranslated;
  logic              region_err;
  logic [ADDR_W-1:0] direct_paddr;
  logic [ADDR_W-1:0] fixed_paddr;
  verdict_t          lk_verdict;

  logic              nxt_valid;
  logic [ADDR_W-1:0] nxt_paddr;
  logic              nxt_fault;
  logic [CODE_W-1:0] nxt_code;

  vg_region_dec #(.ADDR_W(ADDR_W), .KEEP_W(KEEP_W)) i_region (
    .clk          (clk),
    .rst_n        (rst_n),
    .vaddr        (req_vaddr),
    .priv         (req_priv),
    .untranslated (untranslated),
    .region_err   (region_err),
    .direct_paddr (direct_paddr),
    .fixed_paddr  (fixed_paddr)
  );

  vg_prot_chk i_prot (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (acc_kind_e'(req_kind)),
    .priv    (req_priv),
    .lk      (lookup_e'(tlb_state)),
    .prot    (tlb_prot),
    .dirty   (tlb_dirty),
    .verdict (lk_verdict)
  );

  // next-state
  always_comb begin
    nxt_valid = req_valid;
    nxt_paddr = rsp_paddr;
    nxt_fault = rsp_fault;
    nxt_code  = rsp_code;
    if (req_valid) begin
      if (region_err) begin
        nxt_fault = 1'b1;
        nxt_code  = (req_kind == ACC_WRITE) ? EC_ADDR_WR : EC_ADDR_RD;
        nxt_paddr = '0;
      end else if (untranslated) begin
        nxt_fault = 1'b0;
        nxt_code  = EC_NONE;
        nxt_paddr = fixed_paddr;
      end else if (!xlate_on) begin
        nxt_fault = 1'b0;
        nxt_code  = EC_NONE;
        nxt_paddr = direct_paddr;
      end else begin
        nxt_fault = lk_verdict.fault;
        nxt_code  = lk_verdict.code;
        nxt_paddr = lk_verdict.fault ? '0 : tlb_paddr;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_code  <= '0;
    end else begin
      rsp_valid <= nxt_valid;
      rsp_paddr <= nxt_paddr;
      rsp_fault <= nxt_fault;
      rsp_code  <= nxt_code;
    end
  end

  // R12
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_code)));

  // R11
  fault_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_paddr == '0 && rsp_code != '0));

  // R11
  clean_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |-> (rsp_code == '0));

  // R2
  priv_p12_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv && req_vaddr[ADDR_W-1 -: 2] == 2'b10) |=>
      (!rsp_fault && rsp_paddr[ADDR_W-1:KEEP_W] == '0));

endmodule

// File: tb/test_vaddr_guard.sv
module test_vaddr_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        req_priv;
  logic        xlate_on;
  logic [1:0]  tlb_state;
  logic [1:0]  tlb_prot;
  logic        tlb_dirty;
  logic [31:0] tlb_paddr;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic [11:0] rsp_code;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  vaddr_guard i_vaddr_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_priv(req_priv), .xlate_on(xlate_on),
    .tlb_state(tlb_state), .tlb_prot(tlb_prot), .tlb_dirty(tlb_dirty),
    .tlb_paddr(tlb_paddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_code(rsp_code)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [31:0] addrs [12] = '{32'h0000_1234, 32'h7FFF_FFFC, 32'h8000_0000, 32'hA123_4567,
                              32'hBFFF_FFFF, 32'hC000_0010, 32'hDFFF_FFFF, 32'hE000_0000,
                              32'hE3FF_FFFF, 32'hE400_0000, 32'hE400_0001, 32'hFFFF_FFFF};

  initial begin
    logic        ef;
    logic [11:0] ec;
    logic [31:0] ep;
    string       tag;
    bit          wr;
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_priv = 1'b0;
    xlate_on = 1'b0; tlb_state = '0; tlb_prot = '0; tlb_dirty = 1'b0; tlb_paddr = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", 64'(rsp_valid), 64'd0);
    check("R1 fault", 64'(rsp_fault), 64'd0);
    check("R1 code", 64'(rsp_code), 64'd0);
    check("R1 paddr", 64'(rsp_paddr), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", 64'(rsp_valid), 64'd0);

    for (int a = 0; a < 12; a++)
    for (int k = 0; k < 4; k++)
    for (int p = 0; p < 2; p++)
    for (int x = 0; x < 2; x++)
    for (int s = 0; s < 4; s++)
    for (int r = 0; r < 4; r++)
    for (int d = 0; d < 2; d++) begin
      req_valid = 1'b1; req_vaddr = addrs[a]; req_kind = 2'(k); req_priv = p[0];
      xlate_on = x[0]; tlb_state = 2'(s); tlb_prot = 2'(r); tlb_dirty = d[0];
      tlb_paddr = (addrs[a] ^ 32'h5A5A_0000) + 32'(a * 64 + k);
      wr = (k == 2);
      ef = 1'b0; ec = 12'h000; ep = 32'h0;
      if (p == 0 && ((addrs[a] >= 32'h8000_0000 && addrs[a] < 32'hC000_0000) ||
                     (addrs[a] >= 32'hE000_0000 && addrs[a] > 32'hE400_0000))) begin
        tag = "R3"; ef = 1'b1; ec = wr ? 12'h100 : 12'h0C0;
      end else if (addrs[a] >= 32'h8000_0000 && addrs[a] < 32'hC000_0000) begin
        tag = "R2"; ep = addrs[a] % 32'h2000_0000;
      end else if (addrs[a] >= 32'hE000_0000) begin
        tag = "R4"; ep = addrs[a];
      end else if (x == 0) begin
        tag = "R5"; ep = addrs[a] % 32'h2000_0000;
      end else if (s == 2) begin
        tag = "R6"; ef = 1'b1; ec = 12'h140;
      end else if (s != 1) begin
        tag = "R6"; ef = 1'b1; ec = wr ? 12'h060 : 12'h040;
      end else if (k == 0) begin
        if (p == 1 && r < 2) begin tag = "R8"; ef = 1'b1; ec = 12'h0A0; end
        else begin tag = "R10"; ep = tlb_paddr; end
      end else if ((p == 0 && r < 2) || (wr && (r == 0 || r == 2))) begin
        tag = "R7"; ef = 1'b1; ec = wr ? 12'h0C0 : 12'h0A0;
      end else if (wr && d == 0) begin
        tag = "R9"; ef = 1'b1; ec = 12'h080;
      end else begin
        tag = "R10"; ep = tlb_paddr;
      end
      @(negedge clk);
      check({tag, " fault"}, 64'(rsp_fault), 64'(ef));
      check({tag, " code"}, 64'(rsp_code), 64'(ec));
      if (ef) check("R11 paddr zero on fault", 64'(rsp_paddr), 64'd0);
      else    check({tag, " paddr"}, 64'(rsp_paddr), 64'(ep));
      check("R12 valid", 64'(rsp_valid), 64'd1);
    end

    // R12 hold: final response was a hit or bypass; idle inputs that would fault
    req_vaddr = 32'hA000_0000; req_priv = 1'b1; req_kind = 2'd1; xlate_on = 1'b0;
    @(negedge clk);
    ep = rsp_paddr; ec = rsp_code; ef = rsp_fault;
    req_valid = 1'b0; req_priv = 1'b0; req_kind = 2'd2;
    @(negedge clk);
    check("R12 valid low", 64'(rsp_valid), 64'd0);
    check("R12 paddr held", 64'(rsp_paddr), 64'(ep));
    check("R12 fault held", 64'(rsp_fault), 64'(ef));
    check("R12 code held", 64'(rsp_code), 64'(ec));
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule